// File: doc/BRIEF.md
# Packed fused multiply-add unit

This block is a pipelined execution unit for single-precision fused multiply-add. It works on 128-bit vectors that hold four IEEE-754 binary32 lanes. Each operation takes three source vectors, an opcode byte and a 3-bit operation select.

The opcode byte does two things. It chooses which sources act as the two factors and which acts as the addend. It also chooses between the packed form, where every lane is computed, and the scalar form, where only lane 0 is computed. The operation select chooses one of these forms:

- plain multiply-add;
- multiply-subtract;
- the two forms that negate only the product;
- two alternating forms, in which even and odd lanes add or subtract the addend in opposite ways.

Each computed lane forms the exact product and the exact sum, then rounds once to nearest-even. There is no rounding in between.

An operation is presented with `in_valid` for one cycle. Its result appears on `result` with `out_valid` exactly two cycles later. A new operation may be accepted on every cycle. The destination is understood to be the register that supplied `src1`, so lanes that are not computed return `src1` unchanged.

Top module: `pfma_unit`

## Requirements
- R1: Each computed lane returns round(x·y + z) with one rounding to nearest, ties to even, applied after the exact product and sum. For example, with x = y = 0x3F800800 and z = 0xBF801000 the result is 0x33800000, and 1.0·1.0 + 2^-24 gives 0x3F800000.
- R2: The upper nibble of the opcode selects the operand ordering:
  - 0x9 gives x = src1, y = src3, z = src2;
  - 0xA gives x = src2, y = src1, z = src3;
  - 0xB gives x = src2, y = src3, z = src1.
- R3: Opcodes 0x98, 0xA8 and 0xB8 are the packed form. Opcodes 0x99, 0xA9 and 0xB9 are the scalar form. Any other opcode computes no lane, and the result equals src1 in every lane.
- R4: In scalar form only lane 0 (bits 31:0) is computed. Lanes 1 to 3 of the result equal src1 bit for bit, including NaN patterns.
- R5: The operation select uses these codes:
  - 0: x·y + z;
  - 1: x·y − z;
  - 2: −(x·y) + z;
  - 3: −(x·y) − z;
  - 6 and 7: same as 0.
- R6: With select 4, even lanes (0, 2) compute x·y − z and odd lanes (1, 3) compute x·y + z. Select 5 swaps these assignments.
- R7: Select 3 with all inputs zero returns −0 (0x80000000). An exact zero sum whose two terms have opposite signs returns +0.
- R8: Any NaN input, infinity times zero, or infinities of opposite effective sign in the sum return 0x7FC00000. A result beyond the largest finite value returns infinity with the sign of the exact result.
- R9: Inputs with a zero exponent field are treated as zero of the same sign.
- R10: `out_valid` rises exactly two cycles after an accepted `in_valid`, with its result, and back-to-back operations are accepted every cycle. A synchronous active-high reset clears `out_valid` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| opcode | input | 8 | Ordering and packed/scalar selection |
| op_sel | input | 3 | Add/subtract/negate form |
| src1 | input | 128 | First source, also the pass-through source |
| src2 | input | 128 | Second source |
| src3 | input | 128 | Third source |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Four binary32 results |

## Verification
The bench builds the unit with its default of four lanes. Four lanes place two even and two odd lanes in every vector, so each alternating mode shows its full sign pattern. They also let one scalar operation check three pass-through lanes, one of which carries a NaN pattern. With four lanes, one vector can hold four unrelated corner cases at once: a cancellation that exposes the single rounding, a round-to-even tie, an overflow and a special-value collision. That checks that the lanes are independent.

// File: rtl/pfma_unit.sv
module pfma_unit #(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int MW    = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            opcode,
  input  logic [2:0]            op_sel,
  input  logic [LANES*32-1:0]   src1,
  input  logic [LANES*32-1:0]   src2,
  input  logic [LANES*32-1:0]   src3,
  output logic                  out_valid,
  output logic [LANES*32-1:0]   result
);
  localparam int FW  = EW + MW + 1;
  localparam int SW  = MW + 1;
  localparam int PW  = 2 * SW;
  localparam int GB  = 28;
  localparam int AW  = PW + GB + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EW-1:0] EMAX = '1;
  localparam logic [FW-1:0] QNAN = {1'b0, EMAX, 1'b1, {(MW-1){1'b0}}};

  logic legal, scalar, neg_p;
  logic [1:0] order;
  logic v1, v2;

  assign legal  = (opcode[7:1] == 7'h4C) || (opcode[7:1] == 7'h54) || (opcode[7:1] == 7'h5C);
  assign scalar = opcode[0];
  assign order  = opcode[5:4];
  assign neg_p  = (op_sel == 3'd2) || (op_sel == 3'd3);

  function automatic logic [FW-1:0] sum_round(
    input logic ps, input logic [PW-1:0] pm, input logic signed [10:0] pe,
    input logic zs, input logic [SW-1:0] zm, input logic signed [10:0] ze,
    input logic nan, input logic pinf, input logic zinf,
    input logic pz, input logic zz);
    logic a_is_p, as_, bs, sgn, rup;
    logic [PW-1:0] am, bm;
    logic [AW-1:0] aw, bfull, bw, sum, nrm;
    logic [SW:0] rm;
    int ea, d, lead, be;
    if (nan || (pinf && zinf && (ps != zs))) return QNAN;
    if (pinf) return {ps, EMAX, {MW{1'b0}}};
    if (zinf) return {zs, EMAX, {MW{1'b0}}};
    if (pz && zz) return {(ps == zs) ? ps : 1'b0, {(FW-1){1'b0}}};
    a_is_p = zz || (!pz && (pe >= ze));
    am  = a_is_p ? pm : {zm, {SW{1'b0}}};
    bm  = a_is_p ? {zm, {SW{1'b0}}} : pm;
    as_ = a_is_p ? ps : zs;
    bs  = a_is_p ? zs : ps;
    ea  = a_is_p ? int'(pe) : int'(ze);
    d   = a_is_p ? int'(pe) - int'(ze) : int'(ze) - int'(pe);
    if (d < 0) d = 0;
    if (d > AW - 1) d = AW - 1;
    aw    = {1'b0, am, {GB{1'b0}}};
    bfull = {1'b0, bm, {GB{1'b0}}};
    bw    = bfull >> d;
    bw[0] = bw[0] | (|(bfull & ((AW'(1) << d) - AW'(1))));
    if (as_ == bs) begin
      sum = aw + bw;
      sgn = as_;
    end else if (aw >= bw) begin
      sum = aw - bw;
      sgn = as_;
    end else begin
      sum = bw - aw;
      sgn = bs;
    end
    if (sum == '0) return '0;
    lead = 0;
    for (int i = 0; i < AW; i++) if (sum[i]) lead = i;
    be  = lead + ea + BIAS - GB;
    nrm = sum << (AW - 1 - lead);
    rup = nrm[AW-SW-1] && ((|nrm[AW-SW-2:0]) || nrm[AW-SW]);
    rm  = {1'b0, nrm[AW-1:AW-SW]} + {{SW{1'b0}}, rup};
    be  = be + int'(rm[SW]);
    if (be >= int'(EMAX)) return {sgn, EMAX, {MW{1'b0}}};
    if (be <= 0) return {sgn, {(FW-1){1'b0}}};
    return {sgn, EW'(be), rm[MW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end
  assign out_valid = v2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [FW-1:0] a1, a2, a3, x, y, z;
    logic neg_z, do_lane;
    logic [EW-1:0] xe, ye, ze_raw;
    logic xz, yz, zzr, xinf, yinf, zinfr, xnan, ynan, znan;
    logic [SW-1:0] xm, ym, zmr;

    logic [PW-1:0] r_pm;
    logic signed [10:0] r_pe, r_ze;
    logic [SW-1:0] r_zm;
    logic r_ps, r_zs, r_nan, r_pinf, r_zinf, r_pz, r_zz, r_do;
    logic [FW-1:0] r_pass, r_res;

    assign a1 = src1[g*FW +: FW];
    assign a2 = src2[g*FW +: FW];
    assign a3 = src3[g*FW +: FW];
    assign neg_z = (op_sel == 3'd1) || (op_sel == 3'd3) ||
                   ((op_sel == 3'd4) && (g % 2 == 0)) ||
                   ((op_sel == 3'd5) && (g % 2 == 1));
    assign do_lane = legal && (!scalar || (g == 0));

    always_comb begin
      case (order)
        2'b01:   begin x = a1; y = a3; z = a2; end
        2'b10:   begin x = a2; y = a1; z = a3; end
        default: begin x = a2; y = a3; z = a1; end
      endcase
      x[FW-1] = x[FW-1] ^ neg_p;
      z[FW-1] = z[FW-1] ^ neg_z;
    end

    assign xe = x[FW-2:MW];
    assign ye = y[FW-2:MW];
    assign ze_raw = z[FW-2:MW];
    assign xz = (xe == '0);
    assign yz = (ye == '0);
    assign zzr = (ze_raw == '0);
    assign xinf = (xe == EMAX) && (x[MW-1:0] == '0);
    assign yinf = (ye == EMAX) && (y[MW-1:0] == '0);
    assign zinfr = (ze_raw == EMAX) && (z[MW-1:0] == '0);
    assign xnan = (xe == EMAX) && (x[MW-1:0] != '0);
    assign ynan = (ye == EMAX) && (y[MW-1:0] != '0);
    assign znan = (ze_raw == EMAX) && (z[MW-1:0] != '0);
    assign xm = xz ? '0 : {1'b1, x[MW-1:0]};
    assign ym = yz ? '0 : {1'b1, y[MW-1:0]};
    assign zmr = zzr ? '0 : {1'b1, z[MW-1:0]};

    always_ff @(posedge clk) begin
      r_pm   <= xm * ym;
      r_pe   <= $signed({3'b0, xe}) + $signed({3'b0, ye}) - 11'sd300;
      r_ps   <= x[FW-1] ^ y[FW-1];
      r_zm   <= zmr;
      r_ze   <= $signed({3'b0, ze_raw}) - 11'sd174;
      r_zs   <= z[FW-1];
      r_nan  <= xnan || ynan || znan || (xinf && yz) || (yinf && xz);
      r_pinf <= xinf || yinf;
      r_zinf <= zinfr;
      r_pz   <= xz || yz;
      r_zz   <= zzr;
      r_do   <= do_lane;
      r_pass <= a1;
    end

    always_ff @(posedge clk) begin
      if (rst) r_res <= '0;
      else r_res <= r_do ? sum_round(r_ps, r_pm, r_pe, r_zs, r_zm, r_ze,
                                      r_nan, r_pinf, r_zinf, r_pz, r_zz)
                         : r_pass;
    end

    assign result[g*FW +: FW] = r_res;
  end
endmodule

// File: rtl/pfma_chk.sv
module pfma_chk #(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [7:0]          opcode,
  input logic [2:0]          op_sel,
  input logic [LANES*32-1:0] src1,
  input logic [LANES*32-1:0] src2,
  input logic [LANES*32-1:0] src3,
  input logic                out_valid,
  input logic [LANES*32-1:0] result
);
  logic [1:0] since_rst;
  logic ok_op, nan0;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign ok_op = (opcode == 8'h98) || (opcode == 8'h99) || (opcode == 8'hA8) ||
                 (opcode == 8'hA9) || (opcode == 8'hB8) || (opcode == 8'hB9);
  assign nan0 = ((src1[30:23] == 8'hFF) && (src1[22:0] != 0)) ||
                ((src2[30:23] == 8'hFF) && (src2[22:0] != 0)) ||
                ((src3[30:23] == 8'hFF) && (src3[22:0] != 0));

  // R10
  a_r10_reset_clear: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));

  // R10
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R4
  a_r4_scalar_upper: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 2'd2) && $past(in_valid, 2) && $past(ok_op, 2) && $past(opcode[0], 2))
    |-> (result[LANES*32-1:32] == $past(src1[LANES*32-1:32], 2)));

  // R3
  a_r3_illegal_pass: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 2'd2) && $past(in_valid, 2) && !$past(ok_op, 2))
    |-> (result == $past(src1, 2)));

  // R8
  a_r8_nan_lane0: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 2'd2) && $past(in_valid, 2) && $past(ok_op, 2) && $past(nan0, 2))
    |-> (result[31:0] == 32'h7FC00000));
endmodule

bind pfma_unit pfma_chk #(.LANES(LANES)) u_pfma_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .op_sel(op_sel),
  .src1(src1), .src2(src2), .src3(src3), .out_valid(out_valid), .result(result));

// File: tb/tb_pfma_unit.sv
`timescale 1ns/1ps
module tb_pfma_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] opcode = 8'h98;
  logic [2:0] op_sel = 3'd0;
  logic [127:0] src1 = '0, src2 = '0, src3 = '0;
  logic out_valid;
  logic [127:0] result;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  pfma_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .op_sel(op_sel),
    .src1(src1), .src2(src2), .src3(src3), .out_valid(out_valid), .result(result));

  always #5 clk = ~clk;

  function automatic logic [127:0] rep(input logic [31:0] v);
    return {4{v}};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] opc, input logic [2:0] sel,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    in_valid = 1'b1; opcode = opc; op_sel = sel; src1 = a; src2 = b; src3 = c;
  endtask

  task automatic run(input string tag, input logic [7:0] opc, input logic [2:0] sel,
                     input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                     input logic [127:0] exp);
    @(negedge clk);
    drive(opc, sel, a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid early"}, {127'b0, out_valid}, 128'd0);
    @(negedge clk);
    check({tag, " valid"}, {127'b0, out_valid}, 128'd1);
    check(tag, result, exp);
  endtask

  task automatic t_reset;
    check("R10 reset valid", {127'b0, out_valid}, 128'd0);
    check("R10 reset result", result, 128'd0);
  endtask

  task automatic t_order;
    run("R2 order 132", 8'h98, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'h41300000));
    run("R2 order 213", 8'hA8, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'h41200000));
    run("R2 order 231", 8'hB8, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'h41600000));
  endtask

  task automatic t_ops;
    run("R5 msub", 8'hA8, 3'd1, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'h40000000));
    run("R5 nmadd", 8'hA8, 3'd2, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'hC0000000));
    run("R5 nmsub", 8'hA8, 3'd3, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'hC1200000));
    run("R5 sel7 as madd", 8'hA8, 3'd7, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000), rep(32'h41200000));
  endtask

  task automatic t_alt;
    run("R6 addsub", 8'hA8, 3'd4, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000),
        128'h41200000_40000000_41200000_40000000);
    run("R6 subadd", 8'hA8, 3'd5, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000),
        128'h40000000_41200000_40000000_41200000);
  endtask

  task automatic t_scalar;
    run("R4 scalar pass", 8'h99, 3'd0, 128'hDEADBEEF_7F800001_12345678_40000000,
        rep(32'h40400000), rep(32'h40800000), 128'hDEADBEEF_7F800001_12345678_41300000);
    run("R4 scalar 231", 8'hB9, 3'd1, 128'h00000001_FFFFFFFF_80000000_40000000,
        rep(32'h40400000), rep(32'h40800000), 128'h00000001_FFFFFFFF_80000000_41200000);
  endtask

  task automatic t_illegal;
    run("R3 illegal opcode", 8'h9A, 3'd0, 128'h3F800000_40000000_40400000_40800000,
        rep(32'h40400000), rep(32'h40800000), 128'h3F800000_40000000_40400000_40800000);
    run("R3 illegal opcode C8", 8'hC8, 3'd0, rep(32'h40000000),
        rep(32'h40400000), rep(32'h40800000), rep(32'h40000000));
  endtask

  task automatic t_round;
    run("R1 fused and ties", 8'hA8, 3'd0,
        128'h40000000_3F800000_3F800000_3F800800,
        128'h40400000_3F800000_3F800000_3F800800,
        128'h40800000_33C00000_33800000_BF801000,
        128'h41200000_3F800001_3F800000_33800000);
    run("R1 tie to even odd", 8'hA8, 3'd0, rep(32'h3F800000), rep(32'h3F800001),
        rep(32'h33800000), rep(32'h3F800002));
  endtask

  task automatic t_special;
    run("R8 specials", 8'hA8, 3'd0,
        128'h7F800000_7F000000_7F800000_3F800000,
        128'h3F800000_7F000000_00000000_3F800000,
        128'hFF800000_00000000_3F800000_7F800001,
        128'h7FC00000_7F800000_7FC00000_7FC00000);
    run("R8 negative overflow", 8'hA8, 3'd2, rep(32'h7F000000), rep(32'h7F000000),
        rep(32'h00000000), rep(32'hFF800000));
  endtask

  task automatic t_zero;
    run("R7 nmsub zeros", 8'hA8, 3'd3, rep(32'h0), rep(32'h0), rep(32'h0), rep(32'h80000000));
    run("R7 cancel to +0", 8'hA8, 3'd0,
        128'h3F800000_00000000_40000000_3F800000,
        128'h3F800000_00000000_40000000_3F800000,
        128'hBF800000_80000000_C0800000_BF800000,
        128'h00000000_00000000_00000000_00000000);
  endtask

  task automatic t_denorm;
    run("R9 denormal flush", 8'hA8, 3'd0,
        128'h3F800000_3F800000_3F800000_7F000000,
        128'h3F800000_3F800000_3F800000_00000001,
        128'h3F800000_3F800000_00400000_3F800000,
        128'h40000000_40000000_3F800000_3F800000);
  endtask

  task automatic t_b2b;
    @(negedge clk);
    check("R10 b2b idle", {127'b0, out_valid}, 128'd0);
    drive(8'h98, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000));
    @(negedge clk);
    drive(8'hA8, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000));
    @(negedge clk);
    check("R10 b2b first", result, rep(32'h41300000));
    drive(8'hB8, 3'd0, rep(32'h40000000), rep(32'h40400000), rep(32'h40800000));
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 b2b second", result, rep(32'h41200000));
    check("R10 b2b second valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    check("R10 b2b third", result, rep(32'h41600000));
    @(negedge clk);
    check("R10 b2b drained", {127'b0, out_valid}, 128'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_ops();
    t_alt();
    t_scalar();
    t_illegal();
    t_round();
    t_special();
    t_zero();
    t_denorm();
    t_b2b();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule